// File: doc/BRIEF.md
# Byte Lane Shift and Mask Unit

This unit carries out the byte-manipulation group of integer operate instructions for a 64-bit datapath. It receives operand A, a second operand taken either from a register or from a zero-extended 8-bit literal, a 7-bit function code and a destination register index. One registered result appears in the cycle after the request. The supported functions are byte zeroing under a mask, keeping only masked bytes, low-part extraction of byte/word/long/quad fields, low-byte insertion, low-part masking, and logical shifts left and right.

All functions share one shifter and one per-byte keep mask. Byte-oriented functions shift by eight times the low three bits of B. Bit shifts use the low six bits of B. A keep mask chosen by the function and operand size then clears the result bytes that are not kept. Codes outside the set raise an illegal flag. An illegal request never writes. A destination index of 31 suppresses the write enable.

Top module: `byte_lane_unit`

## Requirements
- R1: A request with `req_valid` high produces `rsp_valid` high on the next rising clock edge. When `req_valid` is low, `rsp_valid` is low on the next edge and `rsp_data`, `rsp_illegal`, `rsp_wr_en` and `rsp_dest` keep their previous values.
- R2: With `use_lit` high, B is the 8-bit `lit` zero-extended to 64 bits and `opb_reg` is ignored. With `use_lit` low, B is `opb_reg`.
- R3: Function 0x30 clears every byte i of A for which B[i] is 1 (i = 0..7). Function 0x31 keeps only those bytes and clears the rest.
- R4: Functions 0x06, 0x16, 0x26 and 0x36 shift A right by 8*B[2:0] bits. They then keep only the low 1, 2, 4 or 8 bytes respectively.
- R5: Functions 0x02, 0x12, 0x22 and 0x32 form the byte mask 0x01, 0x03, 0x0F or 0xFF and shift it left by B[2:0]. Mask bits above byte 7 are dropped. The bytes of A selected by the mask are cleared.
- R6: Function 0x0B shifts A left by 8*B[2:0] bits. It then keeps only byte B[2:0] of the shifted value.
- R7: Function 0x39 shifts A left by B[5:0] bits and function 0x34 shifts A right logically by B[5:0] bits. The upper bits of B have no effect on either.
- R8: Any other function code gives `rsp_illegal` = 1, `rsp_data` = 0 and `rsp_wr_en` = 0.
- R9: `rsp_dest` echoes `dest_idx`. `rsp_wr_en` is 1 for a legal code whose destination is not 31, and 0 when the destination is 31. The result is still computed for destination 31.
- R10: While `rst_n` is low, `rsp_valid`, `rsp_data`, `rsp_illegal`, `rsp_wr_en` and `rsp_dest` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| func | input | 7 | Function code |
| use_lit | input | 1 | Take B from `lit` instead of `opb_reg` |
| lit | input | 8 | Literal operand |
| opa | input | 64 | Operand A |
| opb_reg | input | 64 | Register operand B |
| dest_idx | input | 5 | Destination register index |
| rsp_valid | output | 1 | Result registered this cycle |
| rsp_data | output | 64 | Result |
| rsp_illegal | output | 1 | Function code not supported |
| rsp_wr_en | output | 1 | Result should be written back |
| rsp_dest | output | 5 | Destination index of the result |

## Verification
Write suppression can come from two causes in the same request: an unsupported function code and a destination index of 31. The bench sends one request that has both. It expects the illegal flag set, zero data and no write enable. A second request sends a legal code to destination 31 and checks that the data is still produced while the write stays suppressed. Mask truncation and a byte shift also occur together in a mask-low request with a large offset. There the bench expects only the bytes that remain inside the word to be cleared.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
   localparam int FUNC_W = 7;

   localparam logic [FUNC_W-1:0] F_ZAP    = 7'h30;
   localparam logic [FUNC_W-1:0] F_ZAPNOT = 7'h31;
   localparam logic [FUNC_W-1:0] F_SRL    = 7'h34;
   localparam logic [FUNC_W-1:0] F_SLL    = 7'h39;
   localparam logic [FUNC_W-1:0] F_INSB   = 7'h0B;

   typedef enum logic [2:0] {
      K_NONE,
      K_ZAP,
      K_ZAPNOT,
      K_EXT,
      K_MSK,
      K_INS,
      K_SLL,
      K_SRL
   } op_kind_e;
endpackage

// File: rtl/bmx_decode.sv
module bmx_decode
   import bmx_pkg::*;
(
   input  logic [FUNC_W-1:0] func,
   output op_kind_e          kind,
   output logic [1:0]        size_log2,
   output logic              illegal
);
   always_comb begin
      kind      = K_NONE;
      size_log2 = 2'd0;
      unique case (func)
         F_ZAP:    kind = K_ZAP;
         F_ZAPNOT: kind = K_ZAPNOT;
         F_SRL:    kind = K_SRL;
         F_SLL:    kind = K_SLL;
         F_INSB:   kind = K_INS;
         7'h02, 7'h12, 7'h22, 7'h32: begin
            kind      = K_MSK;
            size_log2 = func[5:4];
         end
         7'h06, 7'h16, 7'h26, 7'h36: begin
            kind      = K_EXT;
            size_log2 = func[5:4];
         end
         default: kind = K_NONE;
      endcase
   end

   assign illegal = (kind == K_NONE);
endmodule

// File: rtl/bmx_mask_gen.sv
module bmx_mask_gen
   import bmx_pkg::*;
#(
   parameter int BYTES = 8,
   localparam int SEL_W = $clog2(BYTES)
) (
   input  op_kind_e         kind,
   input  logic [1:0]       size_log2,
   input  logic [SEL_W-1:0] sel,
   input  logic [BYTES-1:0] zmask,
   output logic [BYTES-1:0] keep
);
   logic [BYTES-1:0]   size_mask;
   logic [2*BYTES-1:0] size_wide;
   logic [2*BYTES-1:0] size_shifted;
   logic [2*BYTES-1:0] one_shifted;

   // Field of 1, 2, 4 or 8 bytes, capped at the word width.
   always_comb begin
      size_mask = '0;
      for (int i = 0; i < BYTES; i++)
         if (i < (1 << size_log2)) size_mask[i] = 1'b1;
   end

   assign size_wide    = {{BYTES{1'b0}}, size_mask};
   assign size_shifted = size_wide << sel;
   assign one_shifted  = {{(2*BYTES-1){1'b0}}, 1'b1} << sel;

   always_comb begin
      keep = '0;
      unique case (kind)
         K_ZAP:        keep = ~zmask;
         K_ZAPNOT:     keep = zmask;
         K_EXT:        keep = size_mask;
         K_MSK:        keep = ~size_shifted[BYTES-1:0];
         K_INS:        keep = one_shifted[BYTES-1:0];
         K_SLL, K_SRL: keep = '1;
         default:      keep = '0;
      endcase
   end

   // R6: insertion keeps exactly one lane
   always_comb
      if (kind == K_INS) a_r6_ins_one_lane: assert ($onehot(keep));
endmodule

// File: rtl/bmx_shifter.sv
module bmx_shifter #(
   parameter int DATA_W      = 64,
   parameter bit LOG_SHIFTER = 1'b1,
   localparam int SHW = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SHW-1:0]    amt,
   input  logic              left,
   output logic [DATA_W-1:0] dout
);
   generate
      if (LOG_SHIFTER) begin : g_log
         logic [DATA_W-1:0] stage [SHW+1];
         assign stage[0] = din;
         for (genvar s = 0; s < SHW; s++) begin : g_stage
            always_comb begin
               if (!amt[s])
                  stage[s+1] = stage[s];
               else if (left)
                  stage[s+1] = stage[s] << (1 << s);
               else
                  stage[s+1] = stage[s] >> (1 << s);
            end
         end
         assign dout = stage[SHW];
      end else begin : g_flat
         assign dout = left ? (din << amt) : (din >> amt);
      end
   endgenerate

   // R7: a zero count passes the operand through untouched
   always_comb
      if (amt == '0) a_r7_zero_count: assert (dout == din);
endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
   import bmx_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int LIT_W       = 8,
   parameter int IDX_W       = 5,
   parameter int ZERO_IDX    = 31,
   parameter bit LOG_SHIFTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [6:0]        func,
   input  logic              use_lit,
   input  logic [LIT_W-1:0]  lit,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb_reg,
   input  logic [IDX_W-1:0]  dest_idx,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_illegal,
   output logic              rsp_wr_en,
   output logic [IDX_W-1:0]  rsp_dest
);
   localparam int BYTES = DATA_W / 8;
   localparam int SEL_W = $clog2(BYTES);
   localparam int SHW   = $clog2(DATA_W);

   generate
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 16");
      end
      if (LIT_W > DATA_W || LIT_W < 1) begin : g_bad_lit
         $error("LIT_W must lie between 1 and DATA_W");
      end
      if (ZERO_IDX >= (1 << IDX_W) || ZERO_IDX < 0) begin : g_bad_idx
         $error("ZERO_IDX must be encodable in IDX_W bits");
      end
      if (SEL_W + 3 != SHW) begin : g_bad_sel
         $error("byte offset and bit count widths disagree");
      end
   endgenerate

   // Operand B selection
   logic [DATA_W-1:0] opb;
   assign opb = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit} : opb_reg;

   // Decode
   op_kind_e   kind;
   logic [1:0] size_log2;
   logic       ill_c;

   bmx_decode u_dec (
      .func      (func),
      .kind      (kind),
      .size_log2 (size_log2),
      .illegal   (ill_c)
   );

   // Shift amount and direction
   logic [SEL_W-1:0] sel;
   logic [SHW-1:0]   amt;
   logic             left;
   assign sel = opb[SEL_W-1:0];

   always_comb begin
      left = (kind == K_INS) || (kind == K_SLL);
      unique case (kind)
         K_SLL, K_SRL: amt = opb[SHW-1:0];
         K_EXT, K_INS: amt = {sel, 3'b000};
         default:      amt = '0;
      endcase
   end

   logic [DATA_W-1:0] shifted;

   bmx_shifter #(
      .DATA_W      (DATA_W),
      .LOG_SHIFTER (LOG_SHIFTER)
   ) u_sh (
      .din  (opa),
      .amt  (amt),
      .left (left),
      .dout (shifted)
   );

   // Per-byte keep mask
   logic [BYTES-1:0] keep;

   bmx_mask_gen #(.BYTES(BYTES)) u_mask (
      .kind      (kind),
      .size_log2 (size_log2),
      .sel       (sel),
      .zmask     (opb[BYTES-1:0]),
      .keep      (keep)
   );

   logic [DATA_W-1:0] res_c;
   generate
      for (genvar b = 0; b < BYTES; b++) begin : g_lane
         assign res_c[8*b +: 8] = keep[b] ? shifted[8*b +: 8] : 8'h00;
      end
   endgenerate

   // Output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_data    <= '0;
         rsp_illegal <= 1'b0;
         rsp_wr_en   <= 1'b0;
         rsp_dest    <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_data    <= res_c;
            rsp_illegal <= ill_c;
            rsp_wr_en   <= !ill_c && (dest_idx != IDX_W'(ZERO_IDX));
            rsp_dest    <= dest_idx;
         end
      end
   end

   // Assertions
   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(rsp_data)));
   a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> (rsp_data == '0 && !rsp_wr_en));
   a_r9_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_dest == IDX_W'(ZERO_IDX)) |-> !rsp_wr_en);
   a_r3_zapnot_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && func == F_ZAPNOT && opb[BYTES-1:0] == '0) |=> rsp_data == '0);
   a_r7_srl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && func == F_SRL && opb[SHW-1:0] == '0) |=> rsp_data == $past(opa));
endmodule

// File: tb/sim_byte_lane_unit.sv
`timescale 1ns/1ps
module sim_byte_lane_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [6:0]  func = '0;
   logic        use_lit = 1'b0;
   logic [7:0]  lit = '0;
   logic [63:0] opa = '0;
   logic [63:0] opb_reg = '0;
   logic [4:0]  dest_idx = '0;
   logic        rsp_valid, rsp_illegal, rsp_wr_en;
   logic [63:0] rsp_data;
   logic [4:0]  rsp_dest;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   byte_lane_unit u0 (
      .clk, .rst_n, .req_valid, .func, .use_lit, .lit, .opa, .opb_reg,
      .dest_idx, .rsp_valid, .rsp_data, .rsp_illegal, .rsp_wr_en, .rsp_dest
   );

   localparam logic [63:0] A0 = 64'h8877_6655_4433_2211;

   typedef struct packed {
      logic [6:0]  f;
      logic [63:0] b;
      logic        ul;
      logic [7:0]  l;
      logic [63:0] exp;
      logic        ill;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VT [NV] = '{
      '{7'h30, 64'hF0, 1'b0, 8'h00, 64'h0000_0000_4433_2211, 1'b0, 8'd3}, // R3 zap
      '{7'h31, 64'hF0, 1'b0, 8'h00, 64'h8877_6655_0000_0000, 1'b0, 8'd3}, // R3 zapnot
      '{7'h31, '1,     1'b1, 8'h81, 64'h8800_0000_0000_0011, 1'b0, 8'd2}, // R2 literal
      '{7'h06, 64'h3,  1'b0, 8'h00, 64'h0000_0000_0000_0044, 1'b0, 8'd4}, // R4 byte
      '{7'h16, 64'h6,  1'b0, 8'h00, 64'h0000_0000_0000_8877, 1'b0, 8'd4}, // R4 word
      '{7'h26, 64'h5,  1'b0, 8'h00, 64'h0000_0000_0088_7766, 1'b0, 8'd4}, // R4 long
      '{7'h36, 64'hA,  1'b0, 8'h00, 64'h0000_8877_6655_4433, 1'b0, 8'd4}, // R4 quad
      '{7'h02, 64'h1,  1'b0, 8'h00, 64'h8877_6655_4433_0011, 1'b0, 8'd5}, // R5 byte
      '{7'h12, 64'h7,  1'b0, 8'h00, 64'h0077_6655_4433_2211, 1'b0, 8'd5}, // R5 word truncated
      '{7'h22, 64'h2,  1'b0, 8'h00, 64'h8877_0000_0000_2211, 1'b0, 8'd5}, // R5 long
      '{7'h32, 64'h3,  1'b0, 8'h00, 64'h0000_0000_0033_2211, 1'b0, 8'd5}, // R5 quad truncated
      '{7'h0B, 64'h2,  1'b0, 8'h00, 64'h0000_0000_0011_0000, 1'b0, 8'd6}, // R6
      '{7'h0B, 64'h7,  1'b0, 8'h00, 64'h1100_0000_0000_0000, 1'b0, 8'd6}, // R6 top lane
      '{7'h39, 64'h44, 1'b0, 8'h00, 64'h8776_6554_4332_2110, 1'b0, 8'd7}, // R7 sll
      '{7'h34, 64'h3F, 1'b0, 8'h00, 64'h0000_0000_0000_0001, 1'b0, 8'd7}, // R7 srl 63
      '{7'h34, '0,     1'b1, 8'h08, 64'h0088_7766_5544_3322, 1'b0, 8'd2}, // R2 literal srl
      '{7'h39, 64'h40, 1'b0, 8'h00, A0,                      1'b0, 8'd7}, // R7 upper bits ignored
      '{7'h07, 64'h0,  1'b0, 8'h00, 64'h0,                   1'b1, 8'd8}  // R8
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                        input logic ul, input logic [7:0] l, input logic [4:0] d);
      @(negedge clk);
      req_valid = 1'b1; func = f; opa = a; opb_reg = b; use_lit = ul; lit = l; dest_idx = d;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 valid", {63'd0, rsp_valid}, 64'd0);
      chk("R10 data", rsp_data, 64'd0);
      chk("R10 flags", {61'd0, rsp_illegal, rsp_wr_en, 1'b0}, 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VT[i].f, A0, VT[i].b, VT[i].ul, VT[i].l, 5'd5);
         chk($sformatf("R%0d data vec%0d", VT[i].req, i), rsp_data, VT[i].exp);
         chk($sformatf("R%0d illegal vec%0d", VT[i].req, i), {63'd0, rsp_illegal}, {63'd0, VT[i].ill});
         chk($sformatf("R9 wr_en vec%0d", i), {63'd0, rsp_wr_en}, {63'd0, !VT[i].ill});
         chk($sformatf("R1 valid vec%0d", i), {63'd0, rsp_valid}, 64'd1);
      end

      // R1: idle cycle holds result, valid drops
      drive(7'h34, A0, 64'h0, 1'b1, 8'h08, 5'd3);
      chk("R1 pre-idle data", rsp_data, 64'h0088_7766_5544_3322);
      req_valid = 1'b0; opa = 64'hFFFF_FFFF_FFFF_FFFF; func = 7'h31; opb_reg = '1;
      @(negedge clk);
      chk("R1 idle valid", {63'd0, rsp_valid}, 64'd0);
      chk("R1 idle data held", rsp_data, 64'h0088_7766_5544_3322);
      chk("R1 idle dest held", {59'd0, rsp_dest}, 64'd3);

      // R2: register B ignored when literal chosen (zap with lit 0 keeps all)
      drive(7'h30, A0, 64'hFF, 1'b1, 8'h00, 5'd4);
      chk("R2 reg operand ignored", rsp_data, A0);

      // R9: destination 31 still computes, no write
      drive(7'h30, A0, 64'h0, 1'b0, 8'h00, 5'd31);
      chk("R9 dest31 data", rsp_data, A0);
      chk("R9 dest31 wr_en", {63'd0, rsp_wr_en}, 64'd0);
      chk("R9 dest echo", {59'd0, rsp_dest}, 64'd31);

      // R8 and R9 together
      drive(7'h7F, A0, 64'h0, 1'b0, 8'h00, 5'd31);
      chk("R8 illegal with dest31", {62'd0, rsp_illegal, rsp_wr_en}, 64'd2);
      chk("R8 illegal data", rsp_data, 64'd0);

      // R10: reset in mid-run clears outputs
      drive(7'h30, A0, 64'h0, 1'b0, 8'h00, 5'd7);
      rst_n = 1'b0;
      #1;
      chk("R10 mid reset data", rsp_data, 64'd0);
      chk("R10 mid reset valid", {58'd0, rsp_dest, rsp_valid}, 64'd0);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule